// File: doc/BRIEF.md
# Display Controller Interrupt Status Unit

This block collects the event pulses of a raster display controller and turns them into status bits and one interrupt line. The pixel pipeline raises single-cycle pulses when a frame finishes, when either of the two frame buffers reaches its end, when a palette load completes, when the pixel FIFO runs dry and when panel synchronisation is lost. Each pulse sets a sticky bit in a raw status word. The bit stays set until software writes a 1 to it.

An enable mask chooses which status bits may raise the interrupt. Software changes the mask through two write-only views: one sets the bits written as 1 and the other clears them, so no read-modify-write is needed. The masked word is raw status AND enable. It can be read at its own address, and the interrupt line is high whenever that word is nonzero. When software finishes servicing, it writes any value to an end-of-interrupt address. The line then drops for one cycle and rises again if any masked bit is still pending, so an edge-sensitive receiver sees a fresh edge.

The register port has a write strobe with address and data, plus an independent combinational read address.

Top module: `disp_irq_stat`

## Requirements
- R1: After a synchronous active-low reset, every status bit and every enable bit is 0, the interrupt line is low and the line is armed.
- R2: An event pulse sets its status bit at the clock edge where it is sampled. The bit positions are: 0 frame done, 2 sync lost, 5 FIFO underflow, 6 palette load done, 8 end of frame for buffer 0, 9 end of frame for buffer 1. The bit stays set with no further pulses.
- R3: A write to address 0 (raw status) clears each status bit written as 1. Bits written as 0 are left unchanged. Reading address 0 returns the raw status word.
- R4: If an event pulse and a clearing write hit the same status bit in the same cycle, the bit is set after that edge.
- R5: A write to address 2 (enable set) sets each enable bit written as 1 and leaves the others unchanged. Reading address 2 or address 3 returns the enable mask.
- R6: A write to address 3 (enable clear) clears each enable bit written as 1 and leaves the others unchanged.
- R7: Reading address 1 returns raw status AND enable mask. Bit positions 1, 3, 4 and 7 and all bits at or above 10 always read 0 at every address and cannot be set or enabled.
- R8: The interrupt output is high exactly when the masked status is nonzero and the line is armed.
- R9: A write of any value to address 4 (end of interrupt) holds the interrupt output low during the following cycle. From the cycle after that, the output follows R8 again.
- R10: Address 4 and addresses 5 to 7 read as 0. Writes to addresses 5 to 7 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ev_frame_done | input | 1 | Frame-done pulse |
| ev_sync_lost | input | 1 | Sync-lost pulse |
| ev_fifo_underflow | input | 1 | FIFO underflow pulse |
| ev_palette_done | input | 1 | Palette load done pulse |
| ev_eof0 | input | 1 | End of frame, buffer 0 |
| ev_eof1 | input | 1 | End of frame, buffer 1 |
| reg_wr | input | 1 | Register write strobe |
| reg_wr_addr | input | ADDR_W | Write address |
| reg_wdata | input | DATA_W | Write data |
| reg_rd_addr | input | ADDR_W | Read address |
| reg_rdata | output | DATA_W | Read data, combinational from reg_rd_addr |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 32-bit data word and a 3-bit address. This puts all eight addresses within reach, including the three unused ones, and lets the bench write to the upper data bits that no status bit backs. A behavioural model predicts the raw word, the mask and the armed state. It is compared on every cycle against the interrupt line and against a read address that the bench varies. Directed sequences cover an event colliding with a clear, end-of-interrupt with and without pending bits, and writes of all ones to the enable registers. A stretch of random event and register traffic follows.

// File: rtl/disp_irq_pkg.sv
// Package: shared widths, bit positions and register addresses of the
// display interrupt status unit. Bit positions are fixed because the
// software side decodes them.
package disp_irq_pkg;

    localparam int STAT_W = 10;

    localparam int BIT_FRAME_DONE = 0;
    localparam int BIT_SYNC_LOST  = 2;
    localparam int BIT_UNDERFLOW  = 5;
    localparam int BIT_PAL_DONE   = 6;
    localparam int BIT_EOF0       = 8;
    localparam int BIT_EOF1       = 9;

    localparam int ADR_RAW    = 0;
    localparam int ADR_MASKED = 1;
    localparam int ADR_EN_SET = 2;
    localparam int ADR_EN_CLR = 3;
    localparam int ADR_EOI    = 4;

    // Mask of status positions that have a flop behind them.
    function automatic logic [STAT_W-1:0] impl_mask();
        logic [STAT_W-1:0] m;
        m = '0;
        m[BIT_FRAME_DONE] = 1'b1;
        m[BIT_SYNC_LOST]  = 1'b1;
        m[BIT_UNDERFLOW]  = 1'b1;
        m[BIT_PAL_DONE]   = 1'b1;
        m[BIT_EOF0]       = 1'b1;
        m[BIT_EOF1]       = 1'b1;
        return m;
    endfunction

endpackage

// File: rtl/evt_status_reg.sv
// Sticky event status register.
// Each implemented bit is set by its event pulse and cleared by a
// write-one strobe. The event wins when both arrive in one cycle.
// Assumes: event pulses and clear strobes are synchronous to clk.
module evt_status_reg #(
    parameter int W = 10,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] ev,
    input  logic [W-1:0] clr,
    output logic [W-1:0] stat
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            // Per-bit status flop: set has priority over clear.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stat[i] <= 1'b0;
                else if (ev[i])
                    stat[i] <= 1'b1;
                else if (clr[i])
                    stat[i] <= 1'b0;
            end
        end else begin : g_tie
            logic unused_in;
            // Unbacked position: reads constant zero.
            assign unused_in = ev[i] ^ clr[i];
            assign stat[i]   = 1'b0;
        end
    end

endmodule

// File: rtl/irq_enable_reg.sv
// Interrupt enable mask driven by separate set and clear strobes.
// Assumes: set and clear never target one bit in the same cycle, since they
// come from different addresses of a single write port. If they did, the
// set would win.
module irq_enable_reg #(
    parameter int W = 10,
    parameter logic [W-1:0] IMPL = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] en
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (IMPL[i]) begin : g_flop
            // Per-bit enable flop.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    en[i] <= 1'b0;
                else if (set[i])
                    en[i] <= 1'b1;
                else if (clr[i])
                    en[i] <= 1'b0;
            end
        end else begin : g_tie
            logic unused_in;
            // Unbacked position: never enabled.
            assign unused_in = set[i] ^ clr[i];
            assign en[i]     = 1'b0;
        end
    end

endmodule

// File: rtl/irq_line_ctrl.sv
// Interrupt line arming.
// An end-of-interrupt strobe disarms the line for exactly one cycle. The
// line is the AND of armed and "any masked bit pending".
// Assumes: pending is derived from registered state.
module irq_line_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic eoi,
    input  logic pending,
    output logic irq
);

    logic armed_q;

    // Arm state: drop for one cycle after an end-of-interrupt write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            armed_q <= 1'b1;
        else
            armed_q <= !eoi;
    end

    // Output gate.
    always_comb irq = armed_q && pending;

endmodule

// File: rtl/disp_irq_stat.sv
// Top level of the display interrupt status unit.
// This module decodes the register port, holds the raw status and the
// enable mask, builds the masked word and drives the interrupt line.
// Assumes: DATA_W >= STAT_W, and the read port is combinational.
module disp_irq_stat
    import disp_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_frame_done,
    input  logic              ev_sync_lost,
    input  logic              ev_fifo_underflow,
    input  logic              ev_palette_done,
    input  logic              ev_eof0,
    input  logic              ev_eof1,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_wr_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic [ADDR_W-1:0] reg_rd_addr,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);

    localparam logic [STAT_W-1:0] IMPL = impl_mask();
    localparam int PAD_W = DATA_W - STAT_W;

    logic [STAT_W-1:0] ev_vec;
    logic [STAT_W-1:0] wbits;
    logic [STAT_W-1:0] stat_clr, en_set, en_clr;
    logic [STAT_W-1:0] stat_q, en_q, masked;
    logic              eoi;
    logic              unused_wdata_hi;

    // Gather event pulses at their architectural bit positions.
    always_comb begin
        ev_vec                 = '0;
        ev_vec[BIT_FRAME_DONE] = ev_frame_done;
        ev_vec[BIT_SYNC_LOST]  = ev_sync_lost;
        ev_vec[BIT_UNDERFLOW]  = ev_fifo_underflow;
        ev_vec[BIT_PAL_DONE]   = ev_palette_done;
        ev_vec[BIT_EOF0]       = ev_eof0;
        ev_vec[BIT_EOF1]       = ev_eof1;
    end

    assign wbits           = reg_wdata[STAT_W-1:0];
    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:STAT_W];

    // Write decode into per-register strobes.
    always_comb begin
        stat_clr = '0;
        en_set   = '0;
        en_clr   = '0;
        eoi      = 1'b0;
        if (reg_wr) begin
            case (int'(reg_wr_addr))
                ADR_RAW:    stat_clr = wbits;
                ADR_EN_SET: en_set   = wbits;
                ADR_EN_CLR: en_clr   = wbits;
                ADR_EOI:    eoi      = 1'b1;
                default:    ;
            endcase
        end
    end

    evt_status_reg #(.W(STAT_W), .IMPL(IMPL)) u_status (
        .clk   (clk),
        .rst_n (rst_n),
        .ev    (ev_vec),
        .clr   (stat_clr),
        .stat  (stat_q)
    );

    irq_enable_reg #(.W(STAT_W), .IMPL(IMPL)) u_enable (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (en_set),
        .clr   (en_clr),
        .en    (en_q)
    );

    // Masked status word.
    assign masked = stat_q & en_q;

    irq_line_ctrl u_line (
        .clk     (clk),
        .rst_n   (rst_n),
        .eoi     (eoi),
        .pending (|masked),
        .irq     (irq)
    );

    // Read multiplexer, zero-extended to the bus width.
    always_comb begin
        case (int'(reg_rd_addr))
            ADR_RAW:    reg_rdata = {{PAD_W{1'b0}}, stat_q};
            ADR_MASKED: reg_rdata = {{PAD_W{1'b0}}, masked};
            ADR_EN_SET,
            ADR_EN_CLR: reg_rdata = {{PAD_W{1'b0}}, en_q};
            default:    reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/disp_irq_stat_chk.sv
// Checker for the display interrupt status unit. It watches the port
// together with the status, enable and armed-output state.
module disp_irq_stat_chk
    import disp_irq_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic [STAT_W-1:0] ev_vec,
    input logic              reg_wr,
    input logic [ADDR_W-1:0] reg_wr_addr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic [STAT_W-1:0] stat_q,
    input logic [STAT_W-1:0] en_q,
    input logic              irq
);

    localparam logic [STAT_W-1:0] IMPL = impl_mask();

    // R2 R4
    event_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ev_vec) |=> ((stat_q & $past(ev_vec)) == $past(ev_vec)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_wr_addr) == ADR_RAW && ev_vec == '0)
        |=> ((stat_q & $past(reg_wdata[STAT_W-1:0])) == '0));

    // R5
    en_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_wr_addr) == ADR_EN_SET)
        |=> ((en_q & $past(reg_wdata[STAT_W-1:0] & IMPL)) == $past(reg_wdata[STAT_W-1:0] & IMPL)));

    // R6
    en_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_wr_addr) == ADR_EN_CLR)
        |=> ((en_q & $past(reg_wdata[STAT_W-1:0])) == '0));

    // R8
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((stat_q & en_q) != '0));

    // R9
    eoi_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && int'(reg_wr_addr) == ADR_EOI) |=> !irq);

    // R7
    unbacked_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((stat_q & ~IMPL) == '0) && ((en_q & ~IMPL) == '0));

endmodule

bind disp_irq_stat disp_irq_stat_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .ev_vec      (ev_vec),
    .reg_wr      (reg_wr),
    .reg_wr_addr (reg_wr_addr),
    .reg_wdata   (reg_wdata),
    .stat_q      (stat_q),
    .en_q        (en_q),
    .irq         (irq)
);

// File: tb/disp_irq_stat_test.sv
module disp_irq_stat_test;

    localparam int CLK_PERIOD = 10;
    localparam int DW = 32;
    localparam int AW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [5:0]    ev = '0;   // {eof1, eof0, pal, underflow, sync, frame}
    logic          reg_wr = 1'b0;
    logic [AW-1:0] reg_wr_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [AW-1:0] reg_rd_addr = '0;
    logic [DW-1:0] reg_rdata;
    logic          irq;

    int n_cmp = 0;
    int n_bad = 0;
    bit cmp_on = 0;

    // Reference model state.
    logic [9:0] m_stat = '0;
    logic [9:0] m_en = '0;
    logic       m_armed = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    disp_irq_stat uut (
        .clk (clk), .rst_n (rst_n),
        .ev_frame_done (ev[0]), .ev_sync_lost (ev[1]),
        .ev_fifo_underflow (ev[2]), .ev_palette_done (ev[3]),
        .ev_eof0 (ev[4]), .ev_eof1 (ev[5]),
        .reg_wr (reg_wr), .reg_wr_addr (reg_wr_addr), .reg_wdata (reg_wdata),
        .reg_rd_addr (reg_rd_addr), .reg_rdata (reg_rdata), .irq (irq)
    );

    function automatic logic [9:0] ev_bits(logic [5:0] e);
        logic [9:0] b = '0;
        b[0] = e[0]; b[2] = e[1]; b[5] = e[2];
        b[6] = e[3]; b[8] = e[4]; b[9] = e[5];
        return b;
    endfunction

    function automatic logic [DW-1:0] m_read(int a);
        case (a)
            0: return DW'(m_stat);
            1: return DW'(m_stat & m_en);
            2, 3: return DW'(m_en);
            default: return '0;
        endcase
    endfunction

    function automatic string rd_tag(int a);
        case (a)
            0: return "R3";
            1: return "R7";
            2, 3: return "R5";
            default: return "R10";
        endcase
    endfunction

    // Model update on each clock from the inputs held since the last edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_stat <= '0; m_en <= '0; m_armed <= 1'b1;
        end else begin
            logic [9:0] w;
            w = reg_wdata[9:0] & 10'h365;
            m_stat <= ((reg_wr && reg_wr_addr == 0) ? (m_stat & ~w) : m_stat) | ev_bits(ev);
            if (reg_wr && reg_wr_addr == 2) m_en <= m_en | w;
            if (reg_wr && reg_wr_addr == 3) m_en <= m_en & ~w;
            m_armed <= !(reg_wr && reg_wr_addr == 4);
        end
    end

    task automatic check(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (cmp_on) begin
            check("R8 irq", DW'(irq), DW'(m_armed && ((m_stat & m_en) != 0)));
            check(rd_tag(int'(reg_rd_addr)), reg_rdata, m_read(int'(reg_rd_addr)));
        end
    end

    task automatic step(logic [5:0] e, logic w, int a, logic [DW-1:0] d);
        ev = e; reg_wr = w; reg_wr_addr = AW'(a); reg_wdata = d;
        @(posedge clk); #1;
        ev = '0; reg_wr = 1'b0;
    endtask

    task automatic expect_rd(int a, logic [DW-1:0] exp, string tag);
        reg_rd_addr = AW'(a);
        @(negedge clk); #1;
        check(tag, reg_rdata, exp);
    endtask

    task automatic expect_irq(logic exp, string tag);
        @(negedge clk); #1;
        check(tag, DW'(irq), DW'(exp));
    endtask

    initial begin : watchdog
        #(CLK_PERIOD * 100000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1 reset values are visible while reset is still applied.
        expect_irq(1'b0, "R1 irq in reset");
        rst_n = 1'b1;
        @(posedge clk); #1;
        cmp_on = 1;
        expect_rd(0, '0, "R1 raw after reset");
        expect_rd(2, '0, "R1 enable after reset");

        // R2: each event lands on its bit position.
        for (int i = 0; i < 6; i++) step(6'(1 << i), 0, 0, 0);
        expect_rd(0, 32'h365, "R2 all events");
        expect_irq(1'b0, "R8 no enables");

        // R3: writing zeros keeps the bits; writing a one clears one bit.
        step(0, 1, 0, 32'h0);
        expect_rd(0, 32'h365, "R3 zero write");
        step(0, 1, 0, 32'h20);
        expect_rd(0, 32'h345, "R3 clear underflow");

        // R4: an event and a clear on bit 8 in the same cycle.
        step(6'b010000, 1, 0, 32'h100);
        expect_rd(0, 32'h345, "R4 event beats clear");

        // R5 and R7: set the enables with all ones, unbacked bits stay 0.
        step(0, 1, 2, 32'hFFFF_FFFF);
        expect_rd(2, 32'h365, "R5 enable all");
        expect_rd(1, 32'h345, "R7 masked");
        expect_irq(1'b1, "R8 pending");

        // R6: clear bits 0, 2 and 6. Bits 8 and 9 stay enabled.
        step(0, 1, 3, 32'h45);
        expect_rd(3, 32'h320, "R6 enable clear");
        expect_rd(1, 32'h300, "R7 masked after clear");

        // R9: end of interrupt with bits still pending.
        step(0, 1, 4, 32'h0);
        expect_irq(1'b0, "R9 dropped");
        @(posedge clk); #1;
        expect_irq(1'b1, "R9 re-asserted");

        // R9 again, after the pending bits are gone.
        step(0, 1, 0, 32'h3FF);
        step(0, 1, 4, 32'h1234);
        @(posedge clk); #1;
        expect_irq(1'b0, "R9 stays low");

        // R10: unused addresses.
        step(0, 1, 6, 32'h3FF);
        expect_rd(5, '0, "R10 unused read");
        expect_rd(4, '0, "R10 eoi read");
        expect_rd(2, 32'h320, "R10 write ignored");

        // Random traffic, checked by the model on every cycle.
        for (int k = 0; k < 3000; k++) begin
            reg_rd_addr = AW'($urandom_range(0, 7));
            step(6'($urandom) & 6'($urandom), ($urandom_range(0, 2) == 0),
                 $urandom_range(0, 7), $urandom);
        end
        repeat (2) @(posedge clk);
        cmp_on = 0;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule